// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block runs the column phase of an SDRAM access once the controller has accepted a read or write command. From the start column and the burst settings it emits one column address per clock: sequential or interleaved wrap order, a length of 1, 2, 4 or 8 beats, or an open-ended page sweep. For reads it raises a data-valid strobe and per-byte output enables that many clocks later, set by the programmed CAS latency. For writes it gives per-byte write enables.

Every new column command is taken at once and replaces whatever burst is running. Burst settings are captured with each command, so the mode inputs may change for the next command while a burst runs. When a command carries the auto-precharge flag and its burst runs to its natural end, a one-cycle end pulse tells the bank tracker that the row may be closed. The memory array and the pad drivers sit outside this block.

Top module: `sdr_burst_seq`

## Requirements
- R1: While reset is low and after its release with no command, `col_vld`, `col_wr`, `rd_valid`, `rd_oe`, `wr_en` and `burst_end` are all low.
- R2: In the cycle `cmd_vld` is high the first beat is issued combinationally: `col_vld`=1, `col_addr`=`cmd_col`, `col_wr`=`cmd_wr`.
- R3: Sequential order: beat k carries the start column with its low log2(L) bits replaced by (start + k) mod L, upper bits held. `mode_bl` codes 0,1,2,3 give L=1,2,4,8. Codes 4 to 6 give L=1.
- R4: Interleaved order (`mode_ilv`=1): beat k carries start XOR k, k < L. Code 7 gives L=8 in this order.
- R5: Code 7 with sequential order is a page burst: the column counts up by one modulo 2^COL_W (512) on every clock with no end until a new command arrives.
- R6: A command during a burst ends that burst in the same cycle. No further beat of the old burst is issued.
- R7: `rd_valid` is high exactly `mode_cl` clocks (1, 2 or 3) after each cycle that carried a read beat.
- R8: `rd_oe[b]` is high only when `rd_valid` is high and `dqm[b]` was low two clocks earlier.
- R9: `wr_en[b]` is high exactly in write-beat cycles in which `dqm[b]` is low in that same cycle.
- R10: With `mode_wr_single`=1 a write command issues one beat only, whatever `mode_bl` holds. Reads keep the programmed length.
- R11: `burst_end` pulses for one clock after the final beat of a burst issued with `cmd_ap`=1. It does not pulse for a burst that was cut off, nor during a page burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | Column command accepted this cycle |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_col | input | COL_W | Start column |
| cmd_ap | input | 1 | Auto-precharge requested |
| mode_cl | input | CL_W | CAS latency, 1..MAX_CL |
| mode_ilv | input | 1 | 0 = sequential, 1 = interleaved |
| mode_bl | input | 3 | Burst length code |
| mode_wr_single | input | 1 | Writes are single-beat |
| dqm | input | NBYTE | Per-byte mask, high = masked |
| col_addr | output | COL_W | Column of the current beat |
| col_vld | output | 1 | A beat is issued this cycle |
| col_wr | output | 1 | The current beat is a write |
| rd_valid | output | 1 | Read data valid at the pins |
| rd_oe | output | NBYTE | Per-byte output-driver enable |
| wr_en | output | NBYTE | Per-byte write enable |
| burst_end | output | 1 | Auto-precharge burst completed |

## Verification
The latency property assumes that `mode_cl` is held at one legal value from the read beat until its data-valid cycle. The stimulus therefore changes `mode_cl` only after enough idle clocks for the read pipeline to drain. Other mode inputs may change between commands, including in the middle of a burst, because the bench model also captures them per command. The mask properties assume that `dqm` is always driven to a known value, and the bench drives it on every cycle. Commands arrive back to back, in the middle of bursts and exactly at burst ends, so that cut-off bursts, page wrap past column 511 and end pulses are all exercised.

// File: rtl/sdr_burst_pkg.sv
// Shared types for the column burst sequencer.
// Assumes burst-length codes 0..3 are powers of two and code 7 is the page burst.
package sdr_burst_pkg;

    localparam logic [2:0] BLC_PAGE = 3'd7;

    // Settings captured with each column command.
    typedef struct packed {
        logic       wr;    // write burst
        logic       ap;    // auto-precharge at natural end
        logic       ilv;   // interleaved order
        logic       page;  // open-ended page burst
        logic [1:0] lg;    // log2 of burst length
    } burst_ctx_t;

    // Decode the mode inputs into a captured burst context.
    function automatic burst_ctx_t make_ctx(input logic wr, input logic ap,
                                            input logic ilv, input logic [2:0] code,
                                            input logic wr_single);
        burst_ctx_t c;
        c.wr   = wr;
        c.ap   = ap;
        c.ilv  = ilv;
        c.page = 1'b0;
        c.lg   = 2'd0;
        if (code == BLC_PAGE) begin
            if (ilv) c.lg = 2'd3;
            else     c.page = 1'b1;
        end else if (code <= 3'd3) begin
            c.lg = code[1:0];
        end
        if (wr && wr_single) begin
            c.page = 1'b0;
            c.lg   = 2'd0;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdr_burst_addr.sv
// Column address generator: issues the first beat combinationally in the
// command cycle, then one beat per clock until the burst length is reached.
// A new command always wins over a running burst.
// Assumes cmd_col is valid whenever cmd_vld is high.
module sdr_burst_addr
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld,
    input  logic             cmd_wr,
    input  logic             cmd_ap,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             mode_ilv,
    input  logic [2:0]       mode_bl,
    input  logic             mode_wr_single,
    output logic [COL_W-1:0] col_addr,
    output logic             col_vld,
    output logic             col_wr,
    output logic             beat_last,
    output logic             beat_ap
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic             active_q;
    burst_ctx_t       ctx_q, cur_ctx;
    logic [COL_W-1:0] start_q, cnt_q;
    logic [COL_W-1:0] cur_start, cur_cnt, span_mask, offs;

    // Select the beat source: new command or the running burst.
    always_comb begin
        cur_ctx   = cmd_vld ? make_ctx(cmd_wr, cmd_ap, mode_ilv, mode_bl, mode_wr_single)
                            : ctx_q;
        cur_start = cmd_vld ? cmd_col : start_q;
        cur_cnt   = cmd_vld ? '0 : cnt_q;
    end

    // Form the wrapped column inside the burst-aligned block.
    always_comb begin
        span_mask = cur_ctx.page ? '1 : ((ONE << cur_ctx.lg) - ONE);
        offs      = cur_ctx.ilv ? (cur_start ^ cur_cnt) : (cur_start + cur_cnt);
        col_addr  = (cur_start & ~span_mask) | (offs & span_mask);
        col_vld   = cmd_vld | active_q;
        col_wr    = col_vld & cur_ctx.wr;
        beat_last = col_vld & ~cur_ctx.page & (cur_cnt == span_mask);
        beat_ap   = cur_ctx.ap;
    end

    // Advance the beat counter and capture a new burst context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            start_q  <= '0;
            ctx_q    <= '0;
        end else if (col_vld) begin
            active_q <= ~beat_last;
            cnt_q    <= cur_cnt + ONE;
            start_q  <= cur_start;
            ctx_q    <= cur_ctx;
        end
    end

endmodule

// File: rtl/sdr_rd_pipe.sv
// Read timing: delays each read beat by the CAS latency to make the
// data-valid strobe, and delays the byte mask by MASK_LAT clocks to gate
// the per-byte output enables.
// Assumes cl stays constant while read beats are in flight, and MAX_CL >= 2.
module sdr_rd_pipe #(
    parameter int NBYTE    = 2,
    parameter int MAX_CL   = 3,
    parameter int MASK_LAT = 2,
    parameter int CL_W     = $clog2(MAX_CL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_beat,
    input  logic [CL_W-1:0]  cl,
    input  logic [NBYTE-1:0] dqm,
    output logic             rd_valid,
    output logic [NBYTE-1:0] rd_oe
);
    logic [MAX_CL-1:0] vld_sr;
    logic [NBYTE-1:0]  dqm_sr [MASK_LAT];

    // Shift the read-beat flags and the mask history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_sr <= '0;
            for (int i = 0; i < MASK_LAT; i++) dqm_sr[i] <= '0;
        end else begin
            vld_sr    <= {vld_sr[MAX_CL-2:0], rd_beat};
            dqm_sr[0] <= dqm;
            for (int i = 1; i < MASK_LAT; i++) dqm_sr[i] <= dqm_sr[i-1];
        end
    end

    // Pick the delay tap that matches the programmed latency.
    always_comb begin
        rd_valid = vld_sr[0];
        for (int k = 1; k < MAX_CL; k++)
            if (int'(cl) == k + 1) rd_valid = vld_sr[k];
    end

    for (genvar b = 0; b < NBYTE; b++) begin : g_oe
        assign rd_oe[b] = rd_valid & ~dqm_sr[MASK_LAT-1][b];
    end

endmodule

// File: rtl/sdr_burst_seq.sv
// Top of the column burst sequencer: address generation, read timing,
// per-byte write enables and the auto-precharge end pulse.
// Assumes the controller has already opened the row and checked bank timing.
module sdr_burst_seq #(
    parameter int COL_W  = 9,
    parameter int NBYTE  = 2,
    parameter int MAX_CL = 3,
    parameter int CL_W   = $clog2(MAX_CL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_ap,
    input  logic [CL_W-1:0]  mode_cl,
    input  logic             mode_ilv,
    input  logic [2:0]       mode_bl,
    input  logic             mode_wr_single,
    input  logic [NBYTE-1:0] dqm,
    output logic [COL_W-1:0] col_addr,
    output logic             col_vld,
    output logic             col_wr,
    output logic             rd_valid,
    output logic [NBYTE-1:0] rd_oe,
    output logic [NBYTE-1:0] wr_en,
    output logic             burst_end
);
    logic beat_last, beat_ap;

    sdr_burst_addr #(.COL_W(COL_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_ap(cmd_ap), .cmd_col(cmd_col),
        .mode_ilv(mode_ilv), .mode_bl(mode_bl), .mode_wr_single(mode_wr_single),
        .col_addr(col_addr), .col_vld(col_vld), .col_wr(col_wr),
        .beat_last(beat_last), .beat_ap(beat_ap)
    );

    sdr_rd_pipe #(.NBYTE(NBYTE), .MAX_CL(MAX_CL), .MASK_LAT(2), .CL_W(CL_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_beat(col_vld & ~col_wr), .cl(mode_cl), .dqm(dqm),
        .rd_valid(rd_valid), .rd_oe(rd_oe)
    );

    // Write mask acts in the same cycle as the write beat.
    for (genvar b = 0; b < NBYTE; b++) begin : g_we
        assign wr_en[b] = col_wr & ~dqm[b];
    end

    // Flag a naturally completed auto-precharge burst one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) burst_end <= 1'b0;
        else        burst_end <= beat_last & beat_ap;
    end

endmodule

// File: rtl/sdr_burst_seq_chk.sv
// Protocol checker for the burst sequencer, bound to every instance of the top.
// Assumes mode_cl is held while reads are in flight and dqm is always known.
module sdr_burst_seq_chk #(
    parameter int COL_W  = 9,
    parameter int NBYTE  = 2,
    parameter int MAX_CL = 3,
    parameter int CL_W   = $clog2(MAX_CL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_vld,
    input logic             cmd_wr,
    input logic [COL_W-1:0] cmd_col,
    input logic             cmd_ap,
    input logic [CL_W-1:0]  mode_cl,
    input logic             mode_ilv,
    input logic [2:0]       mode_bl,
    input logic             mode_wr_single,
    input logic [NBYTE-1:0] dqm,
    input logic [COL_W-1:0] col_addr,
    input logic             col_vld,
    input logic             col_wr,
    input logic             rd_valid,
    input logic [NBYTE-1:0] rd_oe,
    input logic [NBYTE-1:0] wr_en,
    input logic             burst_end
);
    // R2: a command is issued as a beat in its own cycle.
    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |-> (col_vld && col_addr == cmd_col && col_wr == cmd_wr));

    // R7: with latency 2 held, valid follows a read beat by two clocks.
    a_r7_cl2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cl == 2 && $past(mode_cl) == 2 && $past(mode_cl, 2) == 2)
        |-> rd_valid == $past(col_vld && !col_wr, 2));

    // R8: output enables follow the mask sampled two clocks before.
    a_r8_oe_mask: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_oe == ~$past(dqm, 2));

    // R8: no driver enabled without valid data.
    a_r8_oe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe != '0) |-> rd_valid);

    // R9: no write enable outside a write beat.
    a_r9_we_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(col_vld && col_wr) |-> wr_en == '0);

    // R11: the end pulse always follows an issued beat.
    a_r11_end_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |-> $past(col_vld));
endmodule

bind sdr_burst_seq sdr_burst_seq_chk #(
    .COL_W(COL_W), .NBYTE(NBYTE), .MAX_CL(MAX_CL), .CL_W(CL_W)
) u_chk (.*);

// File: tb/sdr_burst_seq_test.sv
// Self-checking bench with a behavioural cycle model compared on every clock.
module sdr_burst_seq_test;
    localparam int COL_W = 9;
    localparam int NBYTE = 2;
    localparam int NCOL  = 512;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             cmd_vld = 1'b0, cmd_wr = 1'b0, cmd_ap = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic [1:0]       mode_cl = 2'd2;
    logic             mode_ilv = 1'b0, mode_wr_single = 1'b0;
    logic [2:0]       mode_bl = 3'd0;
    logic [NBYTE-1:0] dqm = '0;
    logic [COL_W-1:0] col_addr;
    logic             col_vld, col_wr, rd_valid, burst_end;
    logic [NBYTE-1:0] rd_oe, wr_en;

    sdr_burst_seq uut (.*);

    int checks = 0, errors = 0;

    // model state
    bit m_act, m_ilv, m_ap, m_wr, m_pend;
    int m_start, m_cnt, m_len;          // m_len 0 = page burst
    bit rdh [1:3];
    int dq1, dq2;

    task automatic chk(string ctx, string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", ctx, req, act, exp, $time);
        end
    endtask

    function automatic int len_of(int code, bit ilv, bit wr, bit single);
        int l;
        if (code == 7) l = ilv ? 8 : 0;
        else if (code <= 3) l = 1 << code;
        else l = 1;
        if (wr && single) l = 1;
        return l;
    endfunction

    function automatic int addr_of(int s, int k, int l, bit ilv);
        int base;
        if (l == 0) return (s + k) % NCOL;
        base = s - (s % l);
        if (ilv) return base + ((s % l) ^ k);
        return base + (((s % l) + k) % l);
    endfunction

    // One clock: drive, compare against the model, advance the model.
    task automatic cyc(string ctx, bit v, bit w = 0, int col = 0, bit ap = 0, int msk = 0);
        bit e_vld, e_wr, e_last, e_rv, e_ap;
        int e_addr, l, e_oe, e_we;
        cmd_vld = v; cmd_wr = w; cmd_col = COL_W'(col); cmd_ap = ap; dqm = NBYTE'(msk);
        #1;
        if (v) begin
            l = len_of(int'(mode_bl), mode_ilv, w, mode_wr_single);
            e_vld = 1; e_wr = w; e_addr = col; e_last = (l == 1); e_ap = ap;
        end else begin
            l = m_len;
            e_vld = m_act; e_wr = m_act && m_wr; e_ap = m_ap;
            e_addr = m_act ? addr_of(m_start, m_cnt, m_len, m_ilv) : -1;
            e_last = m_act && m_len != 0 && m_cnt == m_len - 1;
        end
        e_rv = rdh[int'(mode_cl)];
        e_oe = e_rv ? (~dq2 & 3) : 0;
        e_we = (e_vld && e_wr) ? (~msk & 3) : 0;
        chk(ctx, v ? "R2 col_vld" : "R6 col_vld", int'(col_vld), int'(e_vld));
        chk(ctx, v ? "R2 col_wr" : "R6 col_wr", int'(col_wr), int'(e_wr));
        if (e_vld)
            chk(ctx, v ? "R2 col_addr" : (m_ilv ? "R4 col_addr" : (m_len == 0 ? "R5 col_addr" : "R3 col_addr")),
                int'(col_addr), e_addr);
        chk(ctx, "R7 rd_valid", int'(rd_valid), int'(e_rv));
        chk(ctx, "R8 rd_oe", int'(rd_oe), e_oe);
        chk(ctx, "R9 wr_en", int'(wr_en), e_we);
        chk(ctx, "R11 burst_end", int'(burst_end), int'(m_pend));
        // advance
        m_pend = e_vld && e_last && e_ap;
        rdh[3] = rdh[2]; rdh[2] = rdh[1]; rdh[1] = e_vld && !e_wr;
        dq2 = dq1; dq1 = msk;
        if (v) begin
            m_start = col; m_wr = w; m_ap = ap; m_ilv = mode_ilv; m_len = l;
            m_cnt = 1; m_act = (l != 1);
        end else if (m_act) begin
            m_cnt++;
            if (e_last) m_act = 0;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(string ctx, int n);
        for (int i = 0; i < n; i++) cyc(ctx, 0);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-R actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("reset", "R1 col_vld", int'(col_vld), 0);
        chk("reset", "R1 rd_valid", int'(rd_valid), 0);
        chk("reset", "R1 wr_en", int'(wr_en), 0);
        chk("reset", "R1 burst_end", int'(burst_end), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after reset", 3);

        // R3 sequential length 4 wrap, latency 2
        mode_cl = 2'd2; mode_ilv = 0; mode_bl = 3'd2;
        cyc("R3 seq4", 1, 0, 5);
        idle("R3 seq4", 6);

        // R4 interleaved length 8, latency 3, mask varies (R8)
        mode_cl = 2'd3; mode_ilv = 1; mode_bl = 3'd3;
        cyc("R4 ilv8", 1, 0, 13, 0, 0);
        for (int k = 1; k < 12; k++) cyc("R4/R8 ilv8", 0, 0, 0, 0, k % 4);

        // R5 page burst across column 511, latency 1, cut off by write (R6, R9)
        mode_cl = 2'd1; mode_ilv = 0; mode_bl = 3'd7;
        cyc("R5 page", 1, 0, 508);
        for (int k = 0; k < 9; k++) cyc("R5 page", 0);
        mode_bl = 3'd1;
        cyc("R6 cut by write", 1, 1, 100, 0, 1);
        cyc("R9 write mask", 0, 0, 0, 0, 2);
        idle("R6 after", 4);

        // R11 completed burst with auto-precharge
        mode_bl = 3'd1;
        cyc("R11 ap2", 1, 0, 30, 1);
        idle("R11 ap2", 4);
        // R11 interrupted burst: no pulse
        mode_bl = 3'd2;
        cyc("R11 cut", 1, 0, 40, 1);
        cyc("R11 cut", 0);
        cyc("R6 new cmd", 1, 0, 50, 0);
        idle("R11 cut", 6);

        // R10 single-beat writes, reads keep length
        mode_wr_single = 1; mode_bl = 3'd3;
        cyc("R10 single write", 1, 1, 20, 1, 2);
        idle("R10 single write", 3);
        cyc("R10 read len8", 1, 0, 20);
        idle("R10 read len8", 10);
        mode_wr_single = 0;

        // R3 reserved code acts as length 1; R4 code 7 interleaved is 8
        mode_bl = 3'd5;
        cyc("R3 code5", 1, 0, 77);
        idle("R3 code5", 3);
        mode_ilv = 1; mode_bl = 3'd7;
        cyc("R4 code7 ilv", 1, 0, 3);
        idle("R4 code7 ilv", 11);

        // R2/R7 commands every clock, latency 3; R9 write masks every clock
        mode_cl = 2'd3; mode_ilv = 0; mode_bl = 3'd2;
        for (int k = 0; k < 6; k++) cyc("R2/R7 back-to-back", 1, 0, 17 * k + 2, 0, k % 4);
        for (int k = 0; k < 4; k++) cyc("R9 back-to-back write", 1, 1, 9 * k, k[0], 3 - k);
        idle("R9 tail", 8);

        summary();
        $finish;
    end
endmodule